// File: doc/BRIEF.md
# CAN Nominal Bit-Timing Sampler

This block lays out the nominal bit time of a CAN node. An upstream prescaler supplies a one-cycle time-quantum tick. The block counts those ticks through three parts of each bit: a one-quantum synchronisation segment, a first time segment that ends at the sample point, and a second time segment that ends at the transmit point. The lengths of the two time segments come from an 8-bit timing word. Each segment runs one quantum longer than its programmed value.

At the sample point the block reads the receive line. It does so either once, or three times with a majority vote. Three-sample mode lengthens the first segment by two quanta so that the extra reads fit inside it. The result is presented as a sampled-bit value with a one-cycle strobe. A second one-cycle strobe marks the end of the bit, where a transmitter launches its next bit.

The timing word can only be written while a configuration-enable input is high. The block raises a flag when the stored word is outside the legal ranges or gives a bit shorter than eight quanta. A hard-sync request snaps the bit back to the start of its synchronisation segment on the next tick.

Top module: `can_bit_timer`

## Requirements
- R1: `wr_data` is stored into `cfg_q` on a cycle where both `wr_en` and `cfg_en` are high. The layout is: bit 7 is the three-sample mode, bits 6:4 are the programmed second segment S2, and bits 3:0 are the programmed first segment S1. A write with `cfg_en` low leaves `cfg_q`, `cfg_invalid` and the bit timing unchanged.
- R2: While `rst` is high, `cfg_q` takes the value 8'h24, and `smp_valid`, `tx_point` and `smp_bit` are 0.
- R3: A bit lasts 1 + L1 + (S2+1) quanta, where L1 = S1+1 in single mode and L1 = S1+3 in three-sample mode. Quanta are indexed from 0, with the sync quantum as index 0. `tx_point` is high for exactly the one cycle after the tick that ends quantum index L1+S2+1, the last quantum of the bit. The next tick starts a new bit at index 0.
- R4: In single mode, `smp_valid` is high for the one cycle after the tick that ends quantum index L1. In that same cycle `smp_bit` equals `rx_in` as it was at that tick.
- R5: In three-sample mode, `smp_bit` at the `smp_valid` pulse is the majority of `rx_in` at the ticks ending quanta L1-2, L1-1 and L1.
- R6: The quantum position changes only on cycles where `tq_tick` is high. A strobe is only ever asserted in the cycle after a tick.
- R7: A hard-sync request, given alone or in the same cycle as a tick, makes the next tick restart the bit at quantum index 0. That tick produces no strobe.
- R8: `cfg_invalid` is 1 exactly when the stored word has S1 < 2, S2 < 1, or S1 + S2 < 5. The mode bit does not affect it.
- R9: `smp_valid` and `tx_point` are never high together. Neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tq_tick | input | 1 | One-cycle time-quantum enable |
| rx_in | input | 1 | Receive line |
| hsync_req | input | 1 | Hard-sync request |
| cfg_en | input | 1 | Configuration enable; gates writes |
| wr_en | input | 1 | Timing-word write strobe |
| wr_data | input | 8 | Timing word to write |
| cfg_q | output | 8 | Stored timing word |
| cfg_invalid | output | 1 | Stored word violates segment rules |
| smp_bit | output | 1 | Sampled bit value |
| smp_valid | output | 1 | One-cycle strobe for smp_bit |
| tx_point | output | 1 | One-cycle end-of-bit transmit strobe |

## Verification
The bench keeps the default field widths, a 4-bit first segment and a 3-bit second segment. With these widths the timing word has only 256 values, so every word is written in turn. Each word is followed by a hard sync and two full bits, with a receive pattern that varies with each quantum. The expected sample index, bit length and majority value are computed arithmetically from the word. This covers every segment length, both sampling modes and every legal and illegal combination. Idle cycles between ticks, writes with configuration disabled, and hard sync both mid-bit and coincident with a tick are added on a fixed word.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } bt_phase_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/bt_cfg_reg.sv
module bt_cfg_reg #(
  parameter int SEG1_W   = 4,
  parameter int SEG2_W   = 3,
  parameter int CFG_W    = 1 + SEG2_W + SEG1_W,
  parameter logic [CFG_W-1:0] RST_CFG = '0,
  parameter int MIN_SUM  = 5,
  parameter int SEG1_MIN = 2,
  parameter int SEG2_MIN = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q,
  output logic             cfg_invalid
);

  function automatic logic word_bad(input logic [CFG_W-1:0] w);
    int s1;
    int s2;
    s1 = int'(w[SEG1_W-1:0]);
    s2 = int'(w[SEG1_W +: SEG2_W]);
    return (s1 < SEG1_MIN) || (s2 < SEG2_MIN) || ((s1 + s2) < MIN_SUM);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= RST_CFG;
      cfg_invalid <= word_bad(RST_CFG);
    end else if (cfg_en && wr_en) begin
      cfg_q       <= wr_data;
      cfg_invalid <= word_bad(wr_data);
    end
  end

endmodule

// File: rtl/bt_seq.sv
module bt_seq
  import can_bt_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tq_tick,
  input  logic              hsync_req,
  input  logic              tri_mode,
  input  logic [SEG1_W-1:0] seg1,
  input  logic [SEG2_W-1:0] seg2,
  output logic              hit_pre,
  output logic              hit_spt,
  output logic              tx_point
);

  logic [CNT_W-1:0] q;
  logic [CNT_W-1:0] len1;
  logic [CNT_W-1:0] last;
  logic             pend;
  logic             restart;
  logic             live;
  logic             hit_end;
  bt_phase_e        phase;

  always_comb begin
    len1    = CNT_W'(seg1) + CNT_W'(1) + (tri_mode ? CNT_W'(2) : CNT_W'(0));
    last    = len1 + CNT_W'(seg2) + CNT_W'(1);
    restart = tq_tick && (pend || hsync_req);
    live    = tq_tick && !restart;
    if (q == '0)        phase = PH_SYNC;
    else if (q <= len1) phase = PH_SEG1;
    else                phase = PH_SEG2;
    hit_spt = live && (phase == PH_SEG1) && (q == len1);
    hit_pre = live && tri_mode && (phase == PH_SEG1) &&
              ((q == len1 - CNT_W'(2)) || (q == len1 - CNT_W'(1)));
    hit_end = live && (q >= last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      pend     <= 1'b0;
      tx_point <= 1'b0;
    end else begin
      tx_point <= hit_end;
      if (tq_tick) begin
        pend <= 1'b0;
        if (restart || (q >= last)) q <= '0;
        else                         q <= q + CNT_W'(1);
      end else if (hsync_req) begin
        pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bt_sampler.sv
module bt_sampler
  import can_bt_pkg::*;
#(
  parameter int EXTRA = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  input  logic tri_mode,
  input  logic hit_pre,
  input  logic hit_spt,
  output logic smp_bit,
  output logic smp_valid
);

  logic [EXTRA-1:0] hist;
  logic             vote;

  generate
    if (EXTRA == 1) begin : g_shift1
      always_ff @(posedge clk) begin
        if (rst)          hist <= '0;
        else if (hit_pre) hist <= rx_in;
      end
    end else begin : g_shiftn
      always_ff @(posedge clk) begin
        if (rst)          hist <= '0;
        else if (hit_pre) hist <= {hist[EXTRA-2:0], rx_in};
      end
    end
  endgenerate

  assign vote = maj3(hist[EXTRA-1], hist[0], rx_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_bit   <= 1'b0;
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= hit_spt;
      if (hit_spt) smp_bit <= tri_mode ? vote : rx_in;
    end
  end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter logic [SEG2_W+SEG1_W:0] RST_CFG = 8'h24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tq_tick,
  input  logic                   rx_in,
  input  logic                   hsync_req,
  input  logic                   cfg_en,
  input  logic                   wr_en,
  input  logic [SEG2_W+SEG1_W:0] wr_data,
  output logic [SEG2_W+SEG1_W:0] cfg_q,
  output logic                   cfg_invalid,
  output logic                   smp_bit,
  output logic                   smp_valid,
  output logic                   tx_point
);

  localparam int CFG_W  = 1 + SEG2_W + SEG1_W;
  localparam int N_MAX  = 1 + (2**SEG1_W + 2) + 2**SEG2_W;
  localparam int CNT_W  = $clog2(N_MAX + 1);
  localparam int MODE_B = CFG_W - 1;

  logic hit_pre;
  logic hit_spt;

  bt_cfg_reg #(
    .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .CFG_W(CFG_W), .RST_CFG(RST_CFG),
    .MIN_SUM(5), .SEG1_MIN(2), .SEG2_MIN(1)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .wr_en(wr_en),
    .wr_data(wr_data), .cfg_q(cfg_q), .cfg_invalid(cfg_invalid)
  );

  bt_seq #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .tq_tick(tq_tick), .hsync_req(hsync_req),
    .tri_mode(cfg_q[MODE_B]), .seg1(cfg_q[SEG1_W-1:0]),
    .seg2(cfg_q[SEG1_W +: SEG2_W]),
    .hit_pre(hit_pre), .hit_spt(hit_spt), .tx_point(tx_point)
  );

  bt_sampler #(.EXTRA(2)) u_smp (
    .clk(clk), .rst(rst), .rx_in(rx_in), .tri_mode(cfg_q[MODE_B]),
    .hit_pre(hit_pre), .hit_spt(hit_spt),
    .smp_bit(smp_bit), .smp_valid(smp_valid)
  );

endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tq_tick,
  input logic                   cfg_en,
  input logic                   wr_en,
  input logic [SEG2_W+SEG1_W:0] wr_data,
  input logic [SEG2_W+SEG1_W:0] cfg_q,
  input logic                   cfg_invalid,
  input logic                   smp_valid,
  input logic                   tx_point
);

  // R1
  wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q));

  // R1
  wr_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && wr_en) |=> (cfg_q == $past(wr_data)));

  // R6
  smp_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(tq_tick));

  // R6
  tx_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    tx_point |-> $past(tq_tick));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && tx_point));

  // R9
  smp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);

  // R9
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_point |=> !tx_point);

  // R8
  invalid_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_invalid == ((int'(cfg_q[SEG1_W-1:0]) < 2) ||
                    (int'(cfg_q[SEG1_W +: SEG2_W]) < 1) ||
                    ((int'(cfg_q[SEG1_W-1:0]) + int'(cfg_q[SEG1_W +: SEG2_W])) < 5)));

endmodule

bind can_bit_timer can_bit_timer_chk #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W)) u_chk (
  .clk(clk), .rst(rst), .tq_tick(tq_tick), .cfg_en(cfg_en), .wr_en(wr_en),
  .wr_data(wr_data), .cfg_q(cfg_q), .cfg_invalid(cfg_invalid),
  .smp_valid(smp_valid), .tx_point(tx_point)
);

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tq_tick = 1'b0;
  logic       rx_in = 1'b0;
  logic       hsync_req = 1'b0;
  logic       cfg_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] cfg_q;
  logic       cfg_invalid;
  logic       smp_bit;
  logic       smp_valid;
  logic       tx_point;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  logic rxs [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bit_timer u_dut (
    .clk(clk), .rst(rst), .tq_tick(tq_tick), .rx_in(rx_in),
    .hsync_req(hsync_req), .cfg_en(cfg_en), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_q(cfg_q), .cfg_invalid(cfg_invalid), .smp_bit(smp_bit),
    .smp_valid(smp_valid), .tx_point(tx_point)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_bad(input logic [7:0] w);
    int s1 = int'(w[3:0]);
    int s2 = int'(w[6:4]);
    return ((s1 < 2) || (s2 < 1) || (s1 + s2 < 5)) ? 1 : 0;
  endfunction

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic write_cfg(input logic en, input logic [7:0] d);
    @(negedge clk);
    cfg_en = en; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    cfg_en = 1'b0; wr_en = 1'b0;
  endtask

  // one tick with outputs sampled after it, then an idle cycle
  task automatic tick(input logic r, input logic hs,
                      output logic sv, output logic sb, output logic tv);
    @(negedge clk);
    tq_tick = 1'b1; rx_in = r; hsync_req = hs;
    @(negedge clk);
    tq_tick = 1'b0; hsync_req = 1'b0;
    sv = smp_valid; sb = smp_bit; tv = tx_point;
    chk("R9 excl", int'(smp_valid & tx_point), 0);
    @(negedge clk);
    chk("R6 idle smp", int'(smp_valid), 0);
    chk("R6 idle tx", int'(tx_point), 0);
  endtask

  task automatic run_bit(input logic [7:0] w, input int salt);
    int l1 = int'(w[3:0]) + 1 + (w[7] ? 2 : 0);
    int nq = 1 + l1 + int'(w[6:4]) + 1;
    logic sv, sb, tv, eb;
    for (int k = 0; k < nq; k++) begin
      rxs[k] = logic'(((k * 5 + salt * 3 + int'(w)) % 7) < 3);
      tick(rxs[k], 1'b0, sv, sb, tv);
      chk("R3 tx", int'(tv), (k == nq - 1) ? 1 : 0);
      if (w[7]) chk("R5 strobe", int'(sv), (k == l1) ? 1 : 0);
      else      chk("R4 strobe", int'(sv), (k == l1) ? 1 : 0);
      if (k == l1) begin
        if (w[7]) begin
          eb = maj(rxs[k-2], rxs[k-1], rxs[k]);
          chk("R5 majority", int'(sb), int'(eb));
        end else begin
          chk("R4 value", int'(sb), int'(rxs[k]));
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic sv, sb, tv;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 cfg", int'(cfg_q), 'h24);
    chk("R2 smp_valid", int'(smp_valid), 0);
    chk("R2 tx", int'(tx_point), 0);
    chk("R2 smp_bit", int'(smp_bit), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset flag", int'(cfg_invalid), exp_bad(8'h24));

    // exhaustive sweep of the timing word
    for (int w = 0; w < 256; w++) begin
      write_cfg(1'b1, 8'(w));
      chk("R1 write", int'(cfg_q), w);
      chk("R8 flag", int'(cfg_invalid), exp_bad(8'(w)));
      @(negedge clk); hsync_req = 1'b1;
      @(negedge clk); hsync_req = 1'b0;
      tick(1'b0, 1'b0, sv, sb, tv);
      chk("R7 quiet", int'(sv | tv), 0);
      run_bit(8'(w), 0);
      run_bit(8'(w), 1);
    end

    // R1 write with configuration disabled is ignored
    write_cfg(1'b1, 8'h24);
    write_cfg(1'b0, 8'h81);
    chk("R1 ignored cfg", int'(cfg_q), 'h24);
    chk("R1 ignored flag", int'(cfg_invalid), 0);
    run_bit(8'h24, 2);

    // R7 mid-bit hard sync, request alone
    for (int k = 0; k < 4; k++) tick(1'b1, 1'b0, sv, sb, tv);
    @(negedge clk); hsync_req = 1'b1;
    @(negedge clk); hsync_req = 1'b0;
    tick(1'b1, 1'b0, sv, sb, tv);
    chk("R7 restart quiet", int'(sv | tv), 0);
    run_bit(8'h24, 3);

    // R7 hard sync coincident with tick, in three-sample mode
    write_cfg(1'b1, 8'hB5);
    for (int k = 0; k < 6; k++) tick(1'b0, 1'b0, sv, sb, tv);
    tick(1'b0, 1'b1, sv, sb, tv);
    chk("R7 coincident quiet", int'(sv | tv), 0);
    run_bit(8'hB5, 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule